// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator with Relation Code

This block compares two IEEE 754 single-precision operands and returns a two-bit relation code that a status register can latch for later conditional branching. A caller pulses `in_valid` with both operands. One clock later, `out_valid` pulses together with the relation code and an invalid-operation flag.

The code has four values: equal, less, greater and unordered. Unordered is reported whenever either operand is not a number. Both signed zeros, both infinities, denormals, and quiet and signaling NaNs are handled. Each operand is first classified. The relation is then derived from the signs and from a magnitude comparison of the non-sign bits, which keeps the ordering logic sign-magnitude rather than two's complement.

Top module: `fp_relcmp`

## Requirements
- R1: Code 2'b00 (equal) is produced when both operands have the same value; +0 (0x00000000) and -0 (0x80000000) count as equal.
- R2: Code 2'b01 is produced when operand A is less than operand B.
- R3: Code 2'b10 is produced when operand A is greater than operand B.
- R4: Code 2'b11 (unordered) is produced when either operand is a NaN. A NaN has exponent bits [30:23] all ones and a nonzero fraction [22:0].
- R5: `invalid_op` is 1 on the result cycle if and only if either operand is a signaling NaN, which is a NaN with fraction bit 22 at 0. A quiet NaN (bit 22 at 1) leaves the flag at 0.
- R6: When both operands are negative, the operand with the larger magnitude is the lesser value.
- R7: Infinities (exponent all ones, zero fraction) order below or above every finite value according to their sign, and two infinities of the same sign compare equal.
- R8: Denormal operands (exponent zero, nonzero fraction) are ordered by their magnitude and not flushed to zero.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, carrying that request's result; `invalid_op` is never high without `out_valid`.
- R10: After reset, `out_valid` is 0, `cond_code` is 2'b00 and `invalid_op` is 0.
- R11: Operand changes while `in_valid` is low have no effect: `cond_code` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| cond_code | output | 2 | Relation: 00 equal, 01 less, 10 greater, 11 unordered |
| invalid_op | output | 1 | A signaling NaN was compared |

## Verification
The bench builds the block with its default exponent width of 8 and fraction width of 23, which is the single-precision layout the requirements describe. With these values every operand class can be produced from a few random bits: zeros, denormals, normals, infinities and both kinds of NaN. The random mix therefore covers class pairs such as a denormal against a signed zero, or a signaling NaN against an infinity. A compact reference key ordering computes the expected code, so no hand tables are needed.

// File: rtl/fp_relcmp_pkg.sv
package fp_relcmp_pkg;

    typedef enum logic [1:0] {
        REL_EQ    = 2'b00,
        REL_LT    = 2'b01,
        REL_GT    = 2'b10,
        REL_UNORD = 2'b11
    } rel_code_e;

    typedef struct packed {
        logic      vld;
        rel_code_e code;
        logic      inv;
    } cmp_state_t;

endpackage

// File: rtl/fp_relcmp_classify.sv
module fp_relcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MAG_W  = EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] operand,
    output logic              sign,
    output logic [MAG_W-1:0]  mag,
    output logic              is_zero,
    output logic              is_nan,
    output logic              is_snan
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;

    always_comb begin
        sign     = operand[WORD_W-1];
        mag      = operand[MAG_W-1:0];
        exp_f    = operand[MAG_W-1:FRAC_W];
        frac_f   = operand[FRAC_W-1:0];
        exp_ones = &exp_f;
        is_zero  = (mag == '0);
        is_nan   = exp_ones && (frac_f != '0);
        is_snan  = is_nan && !frac_f[FRAC_W-1];
    end

endmodule

// File: rtl/fp_relcmp_magcmp.sv
module fp_relcmp_magcmp #(
    parameter int MAG_W = 31
) (
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output logic             a_lt_b,
    output logic             a_eq_b
);
    always_comb begin
        a_lt_b = (mag_a < mag_b);
        a_eq_b = (mag_a == mag_b);
    end

endmodule

// File: rtl/fp_relcmp.sv
module fp_relcmp
    import fp_relcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MAG_W  = EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [1:0]        cond_code,
    output logic              invalid_op
);
    logic [WORD_W-1:0] opnd    [2];
    logic              sgn     [2];
    logic [MAG_W-1:0]  mag     [2];
    logic              zero_w  [2];
    logic              nan_w   [2];
    logic              snan_w  [2];
    logic              mag_lt, mag_eq;

    cmp_state_t st_d, st_q;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fp_relcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .operand (opnd[gi]),
            .sign    (sgn[gi]),
            .mag     (mag[gi]),
            .is_zero (zero_w[gi]),
            .is_nan  (nan_w[gi]),
            .is_snan (snan_w[gi])
        );
    end

    fp_relcmp_magcmp #(.MAG_W(MAG_W)) u_mag (
        .mag_a  (mag[0]),
        .mag_b  (mag[1]),
        .a_lt_b (mag_lt),
        .a_eq_b (mag_eq)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.inv = 1'b0;
        if (in_valid) begin
            if (nan_w[0] || nan_w[1]) begin
                st_d.code = REL_UNORD;
                st_d.inv  = snan_w[0] || snan_w[1];
            end else if (zero_w[0] && zero_w[1]) begin
                st_d.code = REL_EQ;
            end else if (sgn[0] != sgn[1]) begin
                st_d.code = sgn[0] ? REL_LT : REL_GT;
            end else if (mag_eq) begin
                st_d.code = REL_EQ;
            end else if (mag_lt ^ sgn[0]) begin
                st_d.code = REL_LT;
            end else begin
                st_d.code = REL_GT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, code: REL_EQ, inv: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign cond_code  = st_q.code;
    assign invalid_op = st_q.inv;

    p_done_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_flag_only_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_op |-> out_valid);
    p_code_held_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cond_code));
    p_nan_gives_unord_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (nan_w[0] || nan_w[1])) |=> (cond_code == REL_UNORD));
    p_snan_raises_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (snan_w[0] || snan_w[1])) |=> invalid_op);
    p_zeros_equal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_w[0] && zero_w[1]) |=> (cond_code == REL_EQ));

endmodule

// File: tb/tb_fp_relcmp.sv
module tb_fp_relcmp;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        out_valid, invalid_op;
    logic [1:0]  cond_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_relcmp dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .cond_code(cond_code), .invalid_op(invalid_op)
    );

    function automatic bit is_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit is_snan(logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction

    // Monotone unsigned key: larger key means larger value.
    function automatic logic [31:0] order_key(logic [31:0] x);
        if (x[30:0] == 0) return 32'h8000_0000;
        if (x[31]) return ~x;
        return x | 32'h8000_0000;
    endfunction

    function automatic logic [1:0] exp_code(logic [31:0] a, logic [31:0] b);
        logic [31:0] ka, kb;
        if (is_nan(a) || is_nan(b)) return 2'b11;
        ka = order_key(a);
        kb = order_key(b);
        if (ka == kb) return 2'b00;
        return (ka < kb) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [31:0] rand_op();
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 8)
            0: return {r[31], 31'd0};
            1: return {r[31], 8'hFF, 23'd0};
            2: return {r[31], 8'hFF, 1'b1, r[21:0]};
            3: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
            4: return {r[31], 8'h00, r[22:1], 1'b1};
            default: return {r[31], (r[30:23] == 8'hFF) ? 8'hFE : r[30:23], r[22:0]};
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic string code_req(logic [1:0] c);
        case (c)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic compare(logic [31:0] a, logic [31:0] b, string req);
        logic [1:0] ec;
        bit ei;
        ec = exp_code(a, b);
        ei = is_snan(a) || is_snan(b);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, {"R9 ", req}, 32'(out_valid), 32'd1);
        check(cond_code == ec, req, 32'(cond_code), 32'(ec));
        check(invalid_op == ei, {"R5 ", req}, 32'(invalid_op), 32'(ei));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] held;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
        check(cond_code == 2'b00, "R10", 32'(cond_code), 32'd0);
        check(invalid_op == 1'b0, "R10", 32'(invalid_op), 32'd0);
        rst_n = 1'b1;

        compare(32'h0000_0000, 32'h8000_0000, "R1");
        compare(32'h3F80_0000, 32'h4000_0000, "R2");
        compare(32'h4000_0000, 32'h3F80_0000, "R3");
        compare(32'h7FC0_0000, 32'h3F80_0000, "R4");
        compare(32'h3F80_0000, 32'h7F80_0001, "R5");
        compare(32'hFFC0_0001, 32'h7F80_0000, "R5");
        compare(32'hC000_0000, 32'hBF80_0000, "R6");
        compare(32'hBF80_0000, 32'hC000_0000, "R6");
        compare(32'h7F80_0000, 32'h7F7F_FFFF, "R7");
        compare(32'hFF80_0000, 32'hFF80_0000, "R7");
        compare(32'hFF80_0000, 32'hFF7F_FFFF, "R7");
        compare(32'h0000_0001, 32'h0000_0002, "R8");
        compare(32'h8000_0000, 32'h0000_0001, "R8");
        compare(32'h8000_0003, 32'h8000_0002, "R8");

        // R9: no strobe without a request
        @(negedge clk);
        check(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0);

        // R11: operand changes with in_valid low leave the code alone
        compare(32'h4000_0000, 32'h3F80_0000, "R3");
        held = cond_code;
        for (int i = 0; i < 4; i++) begin
            op_a = 32'h7FC0_0000; op_b = $urandom;
            @(negedge clk);
            check(cond_code == held, "R11", 32'(cond_code), 32'(held));
            check(invalid_op == 1'b0, "R11", 32'(invalid_op), 32'd0);
        end

        for (int i = 0; i < 2000; i++) begin
            logic [31:0] a, b;
            a = rand_op();
            b = ($urandom % 8 == 0) ? a : rand_op();
            compare(a, b, code_req(exp_code(a, b)));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule